// File: doc/BRIEF.md
# Wide-Character UART Receiver with Idle Timeout

This block receives asynchronous serial characters whose data field is programmable from 5 to 14 bits. A parity bit (even, odd or none) and one or two stop bits may follow. The line is resynchronised and then sampled on a clock enable that pulses at sixteen times the bit rate. Each bit is taken at its middle, on the eighth enable of the bit. Each finished character is presented with a one-cycle strobe, together with parity-error, framing-error and break flags. A held-low line is reported as a break. When the line returns high, a second strobe reports how many character times the break lasted.

An idle timer provides message framing. It is armed by every received character. It counts whole character times during which the line stays high, and emits a single pulse once a programmed number of them has passed. A downstream buffer manager can use that pulse to close the current frame. A programmed count of zero turns the timer off.

The receiver keeps no buffer and raises no interrupt. It only produces strobes and flags that the surrounding logic consumes.

Top module: `wide_uart_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `rx_valid`, `brk_end` and `idle_to` are 0 and `rx_data` is 0.
- R2: Data bits are received least significant bit first. `cfg_len` selects 5 to 14 data bits; values below 5 act as 5 and values above 14 act as 14. The character is right-justified in `rx_data`, and the bits above the data length read 0.
- R3: When `cfg_par_en`=1, a parity bit follows the data. With `cfg_par_odd`=0 the data bits plus the parity bit must hold an even number of ones; with `cfg_par_odd`=1 they must hold an odd number. A mismatch sets `rx_par_err` with the strobe. A break never reports a parity error.
- R4: `cfg_two_stop`=1 expects two stop bits, and 0 expects one. `rx_frm_err` is set when any stop sample is low and the character is not a break. After a low final stop bit, the receiver waits for the line to go high before it looks for a new start bit.
- R5: A low level on the line is accepted as a start bit only if it is still low on the eighth enable. A shorter low pulse produces no strobe.
- R6: A character whose data bits are all 0, whose parity sample (if enabled) is 0 and whose stop samples are all 0 is a break. It strobes `rx_valid` with `rx_brk`=1, `rx_frm_err`=0 and `rx_data`=0.
- R7: After a break, `brk_end` pulses for one cycle when the line returns high. `brk_len` then equals 1 plus the number of whole character times the line stayed low after the break strobe.
- R8: One character time is 16 × (1 + data length + parity enable + stop count) enables. `idle_to` pulses once when `cfg_max_idle` whole character times of continuous high line have passed since the last strobe. A low level on the line restarts the partial character time.
- R9: With `cfg_max_idle`=0, `idle_to` never pulses.
- R10: Every `rx_valid` strobe reloads the idle count from `cfg_max_idle`, discarding progress made before it.
- R11: After `idle_to` has pulsed, it does not pulse again until a new character is strobed.
- R12: Nothing advances on clock edges where `tick16` is 0. `rx_valid`, `brk_end` and `idle_to` are raised only on the cycle after an edge with `tick16`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16× the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len | input | 4 | Number of data bits (5 to 14) |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| cfg_max_idle | input | 16 | Idle character times before timeout; 0 disables |
| rx_valid | output | 1 | One-cycle strobe for a finished character |
| rx_data | output | 14 | Received character, right-justified |
| rx_par_err | output | 1 | Parity mismatch on the strobed character |
| rx_frm_err | output | 1 | Low stop sample on a non-break character |
| rx_brk | output | 1 | Strobed character is a break |
| brk_end | output | 1 | One-cycle strobe when a break ends |
| brk_len | output | 16 | Break length in character times, valid with `brk_end` |
| idle_to | output | 1 | One-cycle idle-timeout pulse |

## Verification
`rx_valid` rises three clock cycles after the enable that falls on the middle of the final stop bit: two cycles in the synchroniser and one in the output register. `brk_end` follows the same delay after the first high sample that ends a break. `idle_to` is due the same number of cycles after the last enable of the programmed idle interval. The bench therefore never samples on a fixed edge. A falling-edge monitor counts every strobe and pulse and captures the fields that come with it. Each check is then made at bit boundaries chosen at least half a bit time away from any of these due points, so a result is judged only when its presence or absence is already settled.

// File: rtl/wurx_pkg.sv
// Package: shared constants and types for the wide-character UART receiver.
// Assumes data lengths up to 14 bits and at most one parity and two stop bits.
package wurx_pkg;

    localparam int MIN_BITS = 5;
    localparam int OVERSAMPLE = 16;
    localparam int MID_PHASE = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAITHI,
        ST_BRK
    } rx_state_t;

endpackage

// File: rtl/wurx_sync.sv
// Module: multi-stage synchroniser for the asynchronous serial line.
// Assumes the line idles high; the reset value therefore is high.
module wurx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw line into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) sh_q[0] <= 1'b1;
                    else        sh_q[0] <= din;
                end
            end else begin : g_next
                // Pass the value down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) sh_q[g] <= 1'b1;
                    else        sh_q[g] <= sh_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/wurx_frame.sv
// Module: bit-timing state machine that assembles one character per frame.
// Samples each bit on the eighth enable of its 16-enable period, reports
// parity, framing and break status at the middle of the final stop bit, and
// measures break length in character times. Assumes len is already clamped.
module wurx_frame
    import wurx_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int LEN_W  = 4,
    parameter int TW     = 9,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic [LEN_W-1:0]  len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic [TW-1:0]     char_ticks,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              par_err,
    output logic              frm_err,
    output logic              brk,
    output logic              brk_end,
    output logic [CNT_W-1:0]  brk_len
);
    rx_state_t          st_q;
    logic [3:0]         phase_q;
    logic [LEN_W-1:0]   bit_q;
    logic [DATA_W-1:0]  shf_q;
    logic               par_q;
    logic               stop_idx_q;
    logic               stop_any_q;
    logic               stop_all_q;
    logic [TW-1:0]      chr_q;
    logic [CNT_W-1:0]   bcnt_q;

    logic mid, last;
    logic fin_any, fin_all, fin_brk, last_stop;

    // Decode the sampling point and the end of a bit period.
    always_comb begin
        mid  = (phase_q == 4'(MID_PHASE));
        last = (phase_q == 4'(OVERSAMPLE - 1));
    end

    // Combine the current stop sample with the earlier one to classify the frame.
    always_comb begin
        last_stop = (stop_idx_q == two_stop);
        fin_any   = stop_any_q | ~line;
        fin_all   = stop_all_q & ~line;
        fin_brk   = (shf_q == '0) && !(par_en && par_q) && fin_all;
    end

    // Frame state machine, advanced only on the oversampling enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            phase_q    <= '0;
            bit_q      <= '0;
            shf_q      <= '0;
            par_q      <= 1'b0;
            stop_idx_q <= 1'b0;
            stop_any_q <= 1'b0;
            stop_all_q <= 1'b1;
            chr_q      <= '0;
            bcnt_q     <= '0;
            valid      <= 1'b0;
            data       <= '0;
            par_err    <= 1'b0;
            frm_err    <= 1'b0;
            brk        <= 1'b0;
            brk_end    <= 1'b0;
            brk_len    <= '0;
        end else begin
            valid   <= 1'b0;
            brk_end <= 1'b0;
            if (tick) begin
                case (st_q)
                    ST_IDLE: begin
                        phase_q <= '0;
                        if (!line) st_q <= ST_START;
                    end
                    ST_START: begin
                        phase_q <= phase_q + 4'd1;
                        if (mid && line) begin
                            st_q <= ST_IDLE;
                        end else if (last) begin
                            st_q       <= ST_DATA;
                            phase_q    <= '0;
                            bit_q      <= '0;
                            shf_q      <= '0;
                            par_q      <= 1'b0;
                            stop_idx_q <= 1'b0;
                            stop_any_q <= 1'b0;
                            stop_all_q <= 1'b1;
                        end
                    end
                    ST_DATA: begin
                        phase_q <= phase_q + 4'd1;
                        if (mid) shf_q[bit_q] <= line;
                        if (last) begin
                            phase_q <= '0;
                            if (bit_q == len - LEN_W'(1)) st_q <= par_en ? ST_PAR : ST_STOP;
                            else                          bit_q <= bit_q + LEN_W'(1);
                        end
                    end
                    ST_PAR: begin
                        phase_q <= phase_q + 4'd1;
                        if (mid) par_q <= line;
                        if (last) begin
                            phase_q <= '0;
                            st_q    <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        phase_q <= phase_q + 4'd1;
                        if (mid && last_stop) begin
                            valid   <= 1'b1;
                            data    <= shf_q;
                            brk     <= fin_brk;
                            frm_err <= fin_any && !fin_brk;
                            par_err <= par_en && !fin_brk && (^shf_q ^ par_q ^ par_odd);
                            phase_q <= '0;
                            if (fin_brk) begin
                                st_q   <= ST_BRK;
                                bcnt_q <= CNT_W'(1);
                                chr_q  <= '0;
                            end else if (!line) begin
                                st_q <= ST_WAITHI;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end else begin
                            if (mid) begin
                                stop_any_q <= fin_any;
                                stop_all_q <= fin_all;
                            end
                            if (last) begin
                                phase_q    <= '0;
                                stop_idx_q <= 1'b1;
                            end
                        end
                    end
                    ST_WAITHI: begin
                        if (line) st_q <= ST_IDLE;
                    end
                    ST_BRK: begin
                        if (line) begin
                            brk_end <= 1'b1;
                            brk_len <= bcnt_q;
                            st_q    <= ST_IDLE;
                        end else if (chr_q == char_ticks - TW'(1)) begin
                            chr_q <= '0;
                            if (bcnt_q != '1) bcnt_q <= bcnt_q + CNT_W'(1);
                        end else begin
                            chr_q <= chr_q + TW'(1);
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/wurx_idle.sv
// Module: idle-character timer used for message framing.
// Counts whole character times of continuous high line after each received
// character and pulses once when the programmed number has elapsed.
// Assumes char_done is a one-cycle pulse; a zero maximum never arms.
module wurx_idle #(
    parameter int TW    = 9,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    input  logic [TW-1:0]    char_ticks,
    input  logic [CNT_W-1:0] max_idle,
    input  logic             char_done,
    output logic             idle_to
);
    logic             armed_q;
    logic [CNT_W-1:0] down_q;
    logic [TW-1:0]    tcnt_q;

    // Reload on a character, then count down whole idle character times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            down_q  <= '0;
            tcnt_q  <= '0;
            idle_to <= 1'b0;
        end else begin
            idle_to <= 1'b0;
            if (char_done) begin
                armed_q <= (max_idle != '0);
                down_q  <= max_idle;
                tcnt_q  <= '0;
            end else if (tick && armed_q) begin
                if (!line) begin
                    tcnt_q <= '0;
                end else if (tcnt_q == char_ticks - TW'(1)) begin
                    tcnt_q <= '0;
                    down_q <= down_q - CNT_W'(1);
                    if (down_q == CNT_W'(1)) begin
                        idle_to <= 1'b1;
                        armed_q <= 1'b0;
                    end
                end else begin
                    tcnt_q <= tcnt_q + TW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/wide_uart_rx.sv
// Module: top of the wide-character UART receiver.
// Synchronises the line, clamps the data length, derives the character time
// and connects the frame engine to the idle timer.
// Assumes configuration is held steady while characters are in flight.
module wide_uart_rx #(
    parameter int DATA_W      = 14,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic [CNT_W-1:0]  cfg_max_idle,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_par_err,
    output logic              rx_frm_err,
    output logic              rx_brk,
    output logic              brk_end,
    output logic [CNT_W-1:0]  brk_len,
    output logic              idle_to
);
    import wurx_pkg::*;

    localparam int MAX_CHAR_BITS = DATA_W + 4;
    localparam int TW = $clog2(MAX_CHAR_BITS * OVERSAMPLE + 1);

    logic             line_s;
    logic [LEN_W-1:0] eff_len;
    logic [TW-1:0]    char_ticks;

    wurx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    // Clamp the requested data length to the supported range.
    always_comb begin
        if (cfg_len < LEN_W'(MIN_BITS))     eff_len = LEN_W'(MIN_BITS);
        else if (cfg_len > LEN_W'(DATA_W))  eff_len = LEN_W'(DATA_W);
        else                                eff_len = cfg_len;
    end

    // Character time in enables: start, data, optional parity, stop bits.
    always_comb begin
        char_ticks = TW'((TW'(eff_len) + TW'(2) + TW'(cfg_par_en) + TW'(cfg_two_stop))
                         * TW'(OVERSAMPLE));
    end

    wurx_frame #(
        .DATA_W(DATA_W),
        .LEN_W (LEN_W),
        .TW    (TW),
        .CNT_W (CNT_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .line      (line_s),
        .len       (eff_len),
        .par_en    (cfg_par_en),
        .par_odd   (cfg_par_odd),
        .two_stop  (cfg_two_stop),
        .char_ticks(char_ticks),
        .valid     (rx_valid),
        .data      (rx_data),
        .par_err   (rx_par_err),
        .frm_err   (rx_frm_err),
        .brk       (rx_brk),
        .brk_end   (brk_end),
        .brk_len   (brk_len)
    );

    wurx_idle #(
        .TW   (TW),
        .CNT_W(CNT_W)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .line      (line_s),
        .char_ticks(char_ticks),
        .max_idle  (cfg_max_idle),
        .char_done (rx_valid),
        .idle_to   (idle_to)
    );
endmodule

// File: rtl/wurx_chk.sv
// Module: property checker for the wide-character UART receiver.
// Observes top-level ports only; attached by the bind below.
module wurx_chk #(
    parameter int DATA_W = 14,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick16,
    input logic [LEN_W-1:0]  cfg_len,
    input logic [CNT_W-1:0]  cfg_max_idle,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_par_err,
    input logic              rx_frm_err,
    input logic              rx_brk,
    input logic              brk_end,
    input logic [CNT_W-1:0]  brk_len,
    input logic              idle_to
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !rx_valid && !brk_end && !idle_to && rx_data == '0);

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && cfg_len >= LEN_W'(5) && cfg_len <= LEN_W'(DATA_W)
        |-> (rx_data >> cfg_len) == '0);

    // R3
    brk_no_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_brk |-> !rx_par_err);

    // R6
    brk_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_brk |-> !rx_frm_err && rx_data == '0);

    // R7
    brk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |-> brk_len != '0 && !rx_valid);

    // R9
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_to |-> cfg_max_idle != '0);

    // R11
    idle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_to |=> !idle_to);

    // R12
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16 |=> !rx_valid && !brk_end && !idle_to);
endmodule

bind wide_uart_rx wurx_chk #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W),
    .LEN_W (LEN_W)
) u_wurx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick16      (tick16),
    .cfg_len     (cfg_len),
    .cfg_max_idle(cfg_max_idle),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_par_err  (rx_par_err),
    .rx_frm_err  (rx_frm_err),
    .rx_brk      (rx_brk),
    .brk_end     (brk_end),
    .brk_len     (brk_len),
    .idle_to     (idle_to)
);

// File: tb/test_wide_uart_rx.sv
module test_wide_uart_rx;
    localparam int CLK_PER_BIT = 32;

    typedef struct packed {
        logic [3:0]  len;
        logic        pen;
        logic        podd;
        logic        two;
        logic [13:0] data;
        logic        bad_par;
        logic        bad_stop;
        logic        exp_pe;
        logic        exp_fe;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'd8,  1'b0, 1'b0, 1'b0, 14'h00A5, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd5,  1'b1, 1'b0, 1'b0, 14'h0015, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd14, 1'b1, 1'b1, 1'b1, 14'h2C3A, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd7,  1'b1, 1'b0, 1'b1, 14'h005B, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'd9,  1'b1, 1'b1, 1'b0, 14'h01F0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'd8,  1'b0, 1'b0, 1'b1, 14'h0081, 1'b0, 1'b1, 1'b0, 1'b1},
        '{4'd12, 1'b1, 1'b0, 1'b0, 14'h0FFF, 1'b0, 1'b0, 1'b0, 1'b0},
        '{4'd6,  1'b0, 1'b0, 1'b0, 14'h0001, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b0;
    logic        tick_en = 1'b1;
    logic        rxd = 1'b1;
    logic [3:0]  cfg_len = 4'd8;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic        cfg_two_stop = 1'b0;
    logic [15:0] cfg_max_idle = 16'd0;
    logic        rx_valid, rx_par_err, rx_frm_err, rx_brk, brk_end, idle_to;
    logic [13:0] rx_data;
    logic [15:0] brk_len;

    int nchk = 0, nerr = 0;
    int nval = 0, nidle = 0, nbrk = 0;
    logic [13:0] c_data;
    logic        c_pe, c_fe, c_brk;
    int          c_blen;
    bit          done = 1'b0;

    wide_uart_rx i_wide_uart_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_max_idle(cfg_max_idle),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .brk_end(brk_end),
        .brk_len(brk_len), .idle_to(idle_to)
    );

    always #5 clk = ~clk;

    // Enable at every second clock: 16 enables per bit = 32 clocks.
    always @(posedge clk) tick16 <= rst_n ? (tick_en & ~tick16) : 1'b0;

    // Monitor away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                nval++;
                c_data = rx_data; c_pe = rx_par_err; c_fe = rx_frm_err; c_brk = rx_brk;
            end
            if (idle_to) nidle++;
            if (brk_end) begin nbrk++; c_blen = int'(brk_len); end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic v);
        rxd <= v;
        repeat (CLK_PER_BIT) @(posedge clk);
    endtask

    task automatic hold_high(input int nbits);
        for (int i = 0; i < nbits; i++) bit_out(1'b1);
    endtask

    task automatic send_char(input int len, input bit pen, input bit podd, input bit two,
                             input logic [13:0] d, input bit bad_par, input bit bad_stop);
        logic p;
        p = podd;
        bit_out(1'b0);
        for (int i = 0; i < len; i++) begin
            bit_out(d[i]);
            p = p ^ d[i];
        end
        if (pen) bit_out(p ^ bad_par);
        if (two) bit_out(1'b1);
        bit_out(!bad_stop);
        if (bad_stop) bit_out(1'b1);
    endtask

    task automatic set_cfg(input int len, input bit pen, input bit podd, input bit two,
                           input int maxi);
        cfg_len = 4'(len); cfg_par_en = pen; cfg_par_odd = podd;
        cfg_two_stop = two; cfg_max_idle = 16'(maxi);
    endtask

    initial begin
        int v0, i0;
        repeat (4) @(posedge clk);
        rst_n <= 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet outputs after reset
        chk(!rx_valid && !idle_to && !brk_end, "R1 strobes", int'(rx_valid), 0);
        chk(rx_data == 14'd0, "R1 data", int'(rx_data), 0);
        @(posedge clk);
        hold_high(2);

        // R2, R3, R4: vector table
        foreach (VECS[k]) begin
            logic [13:0] m;
            m = VECS[k].data & 14'((1 << VECS[k].len) - 1);
            set_cfg(VECS[k].len, VECS[k].pen, VECS[k].podd, VECS[k].two, 0);
            v0 = nval;
            send_char(VECS[k].len, VECS[k].pen, VECS[k].podd, VECS[k].two,
                      m, VECS[k].bad_par, VECS[k].bad_stop);
            hold_high(2);
            chk(nval == v0 + 1, "R2 strobe count", nval - v0, 1);
            chk(c_data == m, "R2 data", int'(c_data), int'(m));
            chk(c_pe == VECS[k].exp_pe, "R3 parity flag", int'(c_pe), int'(VECS[k].exp_pe));
            chk(c_fe == VECS[k].exp_fe && !c_brk, "R4 framing flag", int'(c_fe),
                int'(VECS[k].exp_fe));
        end

        // R5: short low pulse is ignored, next character still received
        set_cfg(8, 0, 0, 0, 0);
        v0 = nval;
        rxd <= 1'b0;
        repeat (12) @(posedge clk);
        hold_high(3);
        chk(nval == v0, "R5 glitch ignored", nval - v0, 0);
        send_char(8, 0, 0, 0, 14'h3C, 0, 0);
        hold_high(2);
        chk(nval == v0 + 1 && c_data == 14'h3C, "R5 recovery", int'(c_data), 'h3C);

        // R12: no progress without enable
        tick_en = 1'b0;
        v0 = nval;
        send_char(8, 0, 0, 0, 14'h55, 0, 0);
        hold_high(2);
        chk(nval == v0, "R12 no enable", nval - v0, 0);
        tick_en = 1'b1;
        hold_high(2);

        // R6, R7: break of 35 bit times, 10-bit characters
        v0 = nval; i0 = nbrk;
        for (int i = 0; i < 35; i++) bit_out(1'b0);
        hold_high(3);
        chk(nval == v0 + 1 && c_brk && !c_fe, "R6 break flags", int'(c_brk), 1);
        chk(c_data == 14'd0 && !c_pe, "R6 break data", int'(c_data), 0);
        chk(nbrk == i0 + 1, "R7 break end", nbrk - i0, 1);
        chk(c_blen == 3, "R7 break length", c_blen, 3);

        // R8, R11: timeout after two idle characters, once only
        set_cfg(8, 0, 0, 0, 2);
        i0 = nidle;
        send_char(8, 0, 0, 0, 14'h11, 0, 0);
        hold_high(12);
        chk(nidle == i0, "R8 not yet", nidle - i0, 0);
        hold_high(10);
        chk(nidle == i0 + 1, "R8 timeout", nidle - i0, 1);
        hold_high(30);
        chk(nidle == i0 + 1, "R11 no re-arm", nidle - i0, 1);

        // R10: a new character reloads the count
        i0 = nidle;
        send_char(8, 0, 0, 0, 14'h22, 0, 0);
        hold_high(15);
        send_char(8, 0, 0, 0, 14'h23, 0, 0);
        hold_high(15);
        chk(nidle == i0, "R10 reload", nidle - i0, 0);
        hold_high(10);
        chk(nidle == i0 + 1, "R10 timeout after reload", nidle - i0, 1);

        // R9: zero disables
        set_cfg(8, 0, 0, 0, 0);
        i0 = nidle;
        send_char(8, 0, 0, 0, 14'h33, 0, 0);
        hold_high(40);
        chk(nidle == i0, "R9 disabled", nidle - i0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule